// File: doc/BRIEF.md
# Matrix Keypad Scanner with Event Queue

This block scans a keypad of 8 sense rows and 8 drive columns, plus one special-function key per row that shorts its sense line to ground with no column driven. That makes 72 keys in all. Sense lines are pulled up, so a closed key reads low. A timebase tick paces the scan. When a scan sees that the key map has changed, the block waits a debounce delay and scans again. Only the result of that second scan is taken as the new state.

Each key whose state differs between the confirmed map and the stored map is encoded into one byte and pushed into a 14-entry ordered queue. A host drains the queue with a pop strobe, or re-reads the head entry without consuming it using a peek strobe. The block raises one-cycle pulses for each accepted event, for a confirmed map with more than two closed keys, and for an event dropped because the queue was full.

The scan controller is a state machine with these states:
- `S_GAP`: idle interval between scans.
- `S_SCAN_A`: first scan, nine phases.
- `S_CHECK`: compare the first scan with the stored map.
- `S_HOLD`: debounce wait.
- `S_SCAN_B`: confirming scan.
- `S_EMIT`: walk all 72 keys and push the changed ones.
- `S_COMMIT`: store the confirmed map.

Its transitions are:
- `S_GAP`→`S_SCAN_A` after the gap ticks.
- `S_SCAN_A`→`S_CHECK` after the last phase.
- `S_CHECK`→`S_HOLD` on a difference, otherwise `S_CHECK`→`S_GAP`.
- `S_HOLD`→`S_SCAN_B` when the debounce count expires.
- `S_SCAN_B`→`S_EMIT` after the last phase.
- `S_EMIT`→`S_COMMIT` after key 71.
- `S_COMMIT`→`S_GAP`.

Top module: `keymat_scan_top`

## Requirements
- R1: At most one column output enable is high at a time, and an enabled column is driven low (`col_drv_o` is the inverse of `col_oe_o`). Each scan first samples with no column enabled, then enables columns 0,1,…,7 in turn for one tick each. Each phase is sampled on the tick that ends it.
- R2: An event byte carries the row index 0–7 in bits 6:4 and the slot code in bits 3:0. Matrix column c encodes as c+1, and a row's special-function key encodes as 9.
- R3: Bit 7 of an event byte is 1 for a press and 0 for a release.
- R4: A change is recorded only if it is still present in a confirming scan that starts 3·n ticks after the first scan finds the change. Here n is `dbnc_i`, and `dbnc_i`=0 selects n=3. A key closed only during the first scan produces no event.
- R5: While a row's special-function key is closed, the matrix keys of that row are ignored. They produce neither press nor release events.
- R6: The events of one confirmed scan are pushed in order of slot (columns 0–7, then special-function keys) and, within a slot, in order of row. Presses and releases from the same scan are both recorded.
- R7: `key_ovr_o` pulses once for each confirmed scan that has more than two closed keys (special-function keys included). The events of that scan are still recorded.
- R8: The queue holds up to 14 events in arrival order. A pop or peek of an empty queue returns 0x00.
- R9: An event arriving while the queue holds 14 entries is dropped. `evq_ovr_o` pulses and `evt_new_o` does not.
- R10: A peek strobe returns the head entry without removing it.
- R11: `rd_data_o` shows the result in the cycle after a pop or peek strobe, and `evt_new_o` pulses once per accepted event.
- R12: After reset no column is enabled, `rd_data_o` is 0x00, the queue is empty and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timebase tick pacing scan phases, gap and debounce |
| sense_n_i | input | 8 | Sense rows, low when a key on the row conducts |
| dbnc_i | input | 8 | Debounce setting n; delay is 3·n ticks, 0 selects 3 |
| pop_i | input | 1 | Read and remove the head event |
| peek_i | input | 1 | Read the head event without removing it |
| col_drv_o | output | 8 | Column drive values, low on the enabled column |
| col_oe_o | output | 8 | Column output enables, at most one high |
| rd_data_o | output | 8 | Event byte from the last pop or peek, 0x00 if the queue was empty |
| evt_new_o | output | 1 | Pulse for each event accepted into the queue |
| key_ovr_o | output | 1 | Pulse when a confirmed map has more than two closed keys |
| evq_ovr_o | output | 1 | Pulse when an event was dropped on a full queue |

## Verification
Several properties are checked on every cycle by the assertions:
- the single-column drive;
- the range of the slot code in every pushed byte;
- the rule that a confirming scan only follows the debounce wait;
- the queue occupancy bound;
- the drop-with-pulse behaviour on a full queue;
- the 0x00 result of an empty read;
- the unchanged occupancy after a peek.

Other behaviours only show up in the bench's scenarios:
- the exact event bytes and their order within a scan;
- the masking of a row by its special-function key;
- the suppression of a glitch that vanishes before the confirming scan;
- the scaling of the response time with the debounce setting;
- the single overrun pulse for a three-key chord.

// File: rtl/keymat_pkg.sv
package keymat_pkg;
    localparam int ROWS   = 8;
    localparam int COLS   = 8;
    localparam int SLOTS  = COLS + 1;
    localparam int KEYS   = SLOTS * ROWS;
    localparam int KIDX_W = $clog2(KEYS);
    localparam int PH_W   = $clog2(SLOTS);
    localparam int EV_W   = 8;

    // key map: slot (column or special-function slot) major, row minor
    typedef logic [SLOTS-1:0][ROWS-1:0] keymap_t;

    typedef enum logic [2:0] {
        S_GAP,
        S_SCAN_A,
        S_CHECK,
        S_HOLD,
        S_SCAN_B,
        S_EMIT,
        S_COMMIT
    } scan_st_e;

    // event byte: press flag, row index, slot code (slot + 1)
    function automatic logic [EV_W-1:0] ev_code(input logic press,
                                                input logic [KIDX_W-1:0] k);
        return {press, k[2:0], k[KIDX_W-1:3] + 4'd1};
    endfunction

    function automatic logic [KIDX_W:0] closed_keys(input logic [KEYS-1:0] m);
        logic [KIDX_W:0] n;
        n = '0;
        for (int i = 0; i < KEYS; i++)
            n = n + (KIDX_W+1)'(m[i]);
        return n;
    endfunction
endpackage

// File: rtl/keymat_scanner.sv
module keymat_scanner
    import keymat_pkg::*;
#(
    parameter int GAP_TICKS  = 4,
    parameter int DB_DEFAULT = 3,
    parameter int DB_MULT    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [ROWS-1:0]  sense_n_i,
    input  logic [7:0]       dbnc_i,
    output logic [COLS-1:0]  col_oe_o,
    output logic [COLS-1:0]  col_drv_o,
    output logic             push_o,
    output logic [EV_W-1:0]  push_data_o,
    output logic             key_ovr_o
);
    localparam int GAP_W = $clog2(GAP_TICKS + 1);
    localparam int DB_W  = 8 + $clog2(DB_MULT + 1);
    localparam logic [PH_W-1:0]   PH_LAST = PH_W'(SLOTS - 1);
    localparam logic [KIDX_W-1:0] K_LAST  = KIDX_W'(KEYS - 1);

    scan_st_e          state, state_nx;
    logic [PH_W-1:0]   ph;
    logic [GAP_W-1:0]  gap_cnt;
    logic [DB_W-1:0]   db_cnt, db_load;
    logic [7:0]        db_unit;
    logic [KIDX_W-1:0] kidx;
    keymap_t           samp, stable;
    logic [KEYS-1:0]   samp_flat, stable_flat;

    assign samp_flat   = samp;
    assign stable_flat = stable;

    always_comb begin
        db_unit = (dbnc_i == 8'd0) ? 8'(DB_DEFAULT) : dbnc_i;
        db_load = DB_W'(db_unit) * DB_W'(DB_MULT);
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_GAP:    if (tick_i && gap_cnt == GAP_W'(GAP_TICKS - 1)) state_nx = S_SCAN_A;
            S_SCAN_A: if (tick_i && ph == PH_LAST) state_nx = S_CHECK;
            S_CHECK:  state_nx = (samp != stable) ? S_HOLD : S_GAP;
            S_HOLD:   if (tick_i && db_cnt <= DB_W'(1)) state_nx = S_SCAN_B;
            S_SCAN_B: if (tick_i && ph == PH_LAST) state_nx = S_EMIT;
            S_EMIT:   if (kidx == K_LAST) state_nx = S_COMMIT;
            S_COMMIT: state_nx = S_GAP;
            default:  state_nx = S_GAP;
        endcase
    end

    // state register and scan datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_GAP;
            ph        <= '0;
            gap_cnt   <= '0;
            db_cnt    <= '0;
            kidx      <= '0;
            samp      <= '0;
            stable    <= '0;
            key_ovr_o <= 1'b0;
        end else begin
            state     <= state_nx;
            key_ovr_o <= 1'b0;
            unique case (state)
                S_GAP: begin
                    if (tick_i)
                        gap_cnt <= (state_nx == S_GAP) ? gap_cnt + 1'b1 : '0;
                end
                S_SCAN_A, S_SCAN_B: begin
                    if (tick_i) begin
                        if (ph == '0)
                            samp[SLOTS-1] <= ~sense_n_i;
                        else
                            samp[ph - 1'b1] <= ~sense_n_i & ~samp[SLOTS-1];
                        ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
                    end
                end
                S_CHECK: begin
                    if (state_nx == S_HOLD)
                        db_cnt <= db_load;
                end
                S_HOLD: begin
                    if (tick_i)
                        db_cnt <= db_cnt - 1'b1;
                end
                S_EMIT: begin
                    kidx <= (kidx == K_LAST) ? '0 : kidx + 1'b1;
                end
                S_COMMIT: begin
                    stable    <= samp;
                    key_ovr_o <= (closed_keys(samp_flat) > (KIDX_W+1)'(2));
                end
                default: ;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        col_oe_o    = '0;
        push_o      = 1'b0;
        push_data_o = '0;
        unique case (state)
            S_SCAN_A, S_SCAN_B: begin
                if (ph != '0)
                    col_oe_o[3'(ph - 1'b1)] = 1'b1;
            end
            S_EMIT: begin
                if (samp_flat[kidx] != stable_flat[kidx]) begin
                    push_o      = 1'b1;
                    push_data_o = ev_code(samp_flat[kidx], kidx);
                end
            end
            default: ;
        endcase
        col_drv_o = ~col_oe_o;
    end

    p_one_col_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_oe_o));

    p_code_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (push_data_o[3:0] != 4'd0 && push_data_o[3:0] <= 4'd9));

    p_rescan_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN_B && $past(state) != S_SCAN_B) |-> $past(state) == S_HOLD);

    p_no_drive_while_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> col_oe_o == '0);
endmodule

// File: rtl/keymat_evq.sv
module keymat_evq #(
    parameter int DEPTH = 14,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    input  logic         peek_i,
    output logic [W-1:0] rd_data_o,
    output logic         acc_o,
    output logic         ovr_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] P_LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full, empty, do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push_i && !full;
    assign do_pop  = pop_i && !empty;

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            cnt       <= '0;
            rd_data_o <= '0;
            acc_o     <= 1'b0;
            ovr_o     <= 1'b0;
        end else begin
            acc_o <= do_push;
            ovr_o <= push_i && full;
            if (do_push)
                wr_ptr <= (wr_ptr == P_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == P_LAST) ? '0 : rd_ptr + 1'b1;
            if (pop_i || peek_i)
                rd_data_o <= empty ? '0 : mem[rd_ptr];
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty) |=> rd_data_o == '0);

    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i) |=> (ovr_o && !acc_o));

    p_peek_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_i && !pop_i && !push_i) |=> (cnt == $past(cnt) && rd_ptr == $past(rd_ptr)));
endmodule

// File: rtl/keymat_scan_top.sv
module keymat_scan_top
    import keymat_pkg::*;
#(
    parameter int GAP_TICKS  = 4,
    parameter int DB_DEFAULT = 3,
    parameter int DB_MULT    = 3,
    parameter int EVQ_DEPTH  = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [ROWS-1:0] sense_n_i,
    input  logic [7:0]      dbnc_i,
    input  logic            pop_i,
    input  logic            peek_i,
    output logic [COLS-1:0] col_drv_o,
    output logic [COLS-1:0] col_oe_o,
    output logic [EV_W-1:0] rd_data_o,
    output logic            evt_new_o,
    output logic            key_ovr_o,
    output logic            evq_ovr_o
);
    logic            push;
    logic [EV_W-1:0] push_data;

    keymat_scanner #(
        .GAP_TICKS (GAP_TICKS),
        .DB_DEFAULT(DB_DEFAULT),
        .DB_MULT   (DB_MULT)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .sense_n_i  (sense_n_i),
        .dbnc_i     (dbnc_i),
        .col_oe_o   (col_oe_o),
        .col_drv_o  (col_drv_o),
        .push_o     (push),
        .push_data_o(push_data),
        .key_ovr_o  (key_ovr_o)
    );

    keymat_evq #(
        .DEPTH(EVQ_DEPTH),
        .W    (EV_W)
    ) u_evq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .push_data_i(push_data),
        .pop_i      (pop_i),
        .peek_i     (peek_i),
        .rd_data_o  (rd_data_o),
        .acc_o      (evt_new_o),
        .ovr_o      (evq_ovr_o)
    );
endmodule

// File: tb/keymat_scan_top_test.sv
module keymat_scan_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int QDEPTH     = 14;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pop = 1'b0, peek = 1'b0;
    logic [7:0] sense_n, dbnc = 8'd1;
    logic [7:0] col_drv, col_oe, rd_data, prev_oe;
    logic       evt_new, key_ovr, evq_ovr;

    logic key_m [8][8];
    logic sf_m  [8];

    int checks = 0, fails = 0;
    int nev = 0, nqovr = 0, nkovr = 0, tick_cnt = 0;
    int exp_acc = 0, exp_qovr = 0, exp_kovr = 0;
    logic [7:0] model_q[$];

    keymat_scan_top uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .sense_n_i(sense_n), .dbnc_i(dbnc),
        .pop_i(pop), .peek_i(peek), .col_drv_o(col_drv), .col_oe_o(col_oe),
        .rd_data_o(rd_data), .evt_new_o(evt_new), .key_ovr_o(key_ovr), .evq_ovr_o(evq_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural keypad: closed key conducts the enabled, low-driven column
    always_comb begin
        for (int r = 0; r < 8; r++) begin
            sense_n[r] = ~sf_m[r];
            for (int c = 0; c < 8; c++)
                if (col_oe[c] && !col_drv[c] && key_m[r][c]) sense_n[r] = 1'b0;
        end
    end

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    always @(posedge clk) if (tick) tick_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of drive behaviour and pulse counting
    always @(negedge clk) begin
        if (rst_n) begin
            chk($onehot0(col_oe) && (col_drv == ~col_oe), "R1 single low column", col_oe, col_drv);
            if (col_oe != prev_oe && col_oe != 8'h00)
                chk(col_oe == ((prev_oe == 8'h00) ? 8'h01 : (prev_oe << 1)), "R1 column order",
                    col_oe, (prev_oe == 8'h00) ? 8'h01 : (prev_oe << 1));
            chk(!(evt_new && evq_ovr), "R9 accept and drop together", evt_new, 0);
            if (evt_new) nev++;
            if (evq_ovr) nqovr++;
            if (key_ovr) nkovr++;
        end
        prev_oe = col_oe;
    end

    task automatic expect_ev(input logic [7:0] b);
        if (model_q.size() < QDEPTH) begin
            model_q.push_back(b);
            exp_acc++;
        end else begin
            exp_qovr++;
        end
    endtask

    task automatic pop_chk(input string tag);
        logic [7:0] e;
        e = (model_q.size() > 0) ? model_q.pop_front() : 8'h00;
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk(rd_data == e, tag, rd_data, e);
    endtask

    task automatic peek_chk(input string tag);
        logic [7:0] e;
        e = (model_q.size() > 0) ? model_q[0] : 8'h00;
        peek = 1'b1;
        @(negedge clk);
        peek = 1'b0;
        chk(rd_data == e, tag, rd_data, e);
    endtask

    task automatic drain(input string tag);
        while (model_q.size() > 0) pop_chk(tag);
        pop_chk({tag, " R8 empty read"});
    endtask

    task automatic at_scan_end();
        while (!col_oe[7]) @(negedge clk);
        while (col_oe[7]) @(negedge clk);
    endtask

    task automatic settle();
        repeat (600) @(negedge clk);
    endtask

    task automatic counts_chk(input string tag);
        chk(nev == exp_acc, {tag, " R11 accepted events"}, nev, exp_acc);
        chk(nqovr == exp_qovr, {tag, " R9 drop pulses"}, nqovr, exp_qovr);
        chk(nkovr == exp_kovr, {tag, " R7 overrun pulses"}, nkovr, exp_kovr);
    endtask

    // press one key and measure the ticks until its event is accepted
    task automatic latency(input int n, input int r, input int c, input logic [7:0] code);
        int t0, cyc;
        at_scan_end();
        key_m[r][c] = 1'b1;
        t0 = tick_cnt;
        cyc = 0;
        while (!evt_new && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk((tick_cnt - t0) >= 3*n + 21 && (tick_cnt - t0) <= 3*n + 42,
            "R4 debounce latency", tick_cnt - t0, 3*n + 22);
        expect_ev(code);
        settle();
        at_scan_end();
        key_m[r][c] = 1'b0;
        expect_ev(code & 8'h7f);
        settle();
        pop_chk("R2 R3 press byte");
        pop_chk("R3 release byte");
    endtask

    initial begin
        for (int r = 0; r < 8; r++) begin
            sf_m[r] = 1'b0;
            for (int c = 0; c < 8; c++) key_m[r][c] = 1'b0;
        end
        prev_oe = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(col_oe == 8'h00, "R12 no column after reset", col_oe, 0);
        chk(rd_data == 8'h00, "R12 read data after reset", rd_data, 0);
        chk(!evt_new && !key_ovr && !evq_ovr, "R12 pulses low after reset",
            {evt_new, key_ovr, evq_ovr}, 0);
        pop_chk("R8 empty queue reads zero");

        // response time scales with the debounce setting
        dbnc = 8'd1; latency(1, 3, 5, 8'hB6);
        dbnc = 8'd5; latency(5, 7, 0, 8'hF1);
        dbnc = 8'd0; latency(3, 1, 0, 8'h91);
        counts_chk("latency");

        // R4: closure seen by the first scan only
        dbnc = 8'd5;
        at_scan_end();
        key_m[4][2] = 1'b1;
        while (!col_oe[2]) @(negedge clk);
        while (col_oe[2]) @(negedge clk);
        key_m[4][2] = 1'b0;
        settle();
        counts_chk("R4 glitch");
        pop_chk("R4 glitch leaves queue empty");

        // R5: special-function key masks its row
        dbnc = 8'd1;
        at_scan_end();
        sf_m[2] = 1'b1; key_m[2][3] = 1'b1;
        expect_ev(8'hA9);
        settle();
        at_scan_end();
        key_m[2][3] = 1'b0;
        settle();
        counts_chk("R5 masked release");
        at_scan_end();
        sf_m[2] = 1'b0;
        expect_ev(8'h29);
        settle();
        drain("R5 special key bytes");

        // R6: order within a scan, mixed presses and releases
        at_scan_end();
        key_m[5][1] = 1'b1; key_m[0][6] = 1'b1;
        expect_ev(8'hD2); expect_ev(8'h87);
        settle();
        at_scan_end();
        key_m[5][1] = 1'b0; key_m[2][0] = 1'b1;
        expect_ev(8'hA1); expect_ev(8'h52);
        settle();
        at_scan_end();
        key_m[2][0] = 1'b0; key_m[0][6] = 1'b0;
        expect_ev(8'h21); expect_ev(8'h07);
        settle();
        drain("R6 scan order");
        counts_chk("R6");

        // R7: three-key chord
        at_scan_end();
        key_m[0][0] = 1'b1; key_m[1][1] = 1'b1; key_m[2][2] = 1'b1;
        expect_ev(8'h81); expect_ev(8'h92); expect_ev(8'hA3);
        exp_kovr++;
        settle();
        at_scan_end();
        key_m[0][0] = 1'b0; key_m[1][1] = 1'b0; key_m[2][2] = 1'b0;
        expect_ev(8'h01); expect_ev(8'h12); expect_ev(8'h23);
        settle();
        counts_chk("R7 chord");
        drain("R7 chord bytes");

        // R9 / R8: sixteen events into a fourteen-entry queue
        for (int r = 0; r < 4; r++) begin
            at_scan_end();
            key_m[r][0] = 1'b1; key_m[r][7] = 1'b1;
            expect_ev(8'h81 | 8'(r << 4)); expect_ev(8'h88 | 8'(r << 4));
            settle();
            at_scan_end();
            key_m[r][0] = 1'b0; key_m[r][7] = 1'b0;
            expect_ev(8'h01 | 8'(r << 4)); expect_ev(8'h08 | 8'(r << 4));
            settle();
        end
        counts_chk("R9 overflow");
        peek_chk("R10 peek head");
        peek_chk("R10 peek again");
        pop_chk("R10 pop after peek");
        drain("R8 queue order");
        peek_chk("R8 peek empty");
        counts_chk("final");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule